// File: doc/BRIEF.md
# SPI Slave-Select Controller

This block owns the active-low slave-select lines of an SPI master. The transfer engine loads a target pattern, then asks the block to assert it and later to release it; the block answers with a granted flag that is high exactly while the lines it drives are valid for shifting. The SPI shifting itself lives elsewhere.

Three selection styles are offered. Single mode allows one line low at a time. Decoder mode passes a raw slave number onto the lines for an external decoder. Broadcast mode pulls several lines low together so one write reaches several slaves. A per-line mask keeps chosen lines high in every mode. When a new selection differs from the one just released, the block holds every line high for a minimum gap first. That gap is given in picoseconds and converted to clock cycles. Its default matches 62 ns.

Top module: `spi_ss_ctrl`

## Requirements
- R1: After reset all lines are high, `granted` and `sel_err` are low, and the stored target selects slave 0 (pattern with only bit 0 low). An assert request with no prior load therefore drives bit 0 low.
- R2: The mode code is 2'b00 for single, 2'b01 for decoder and 2'b10 for broadcast. An accepted request with no pending gap drives the target pattern onto `ss_n` and raises `granted` on the first clock edge after the request. In single mode at most one line is ever low.
- R3: In single mode a request is rejected if its target has no low bit, has more than one low bit, or has its low bit on a masked line. Mode 2'b11 is always rejected. A rejected request leaves all lines high and `granted` low, and it sets `sel_err`. The next accepted request clears `sel_err`.
- R4: In decoder mode any target code is accepted, including all-zero, and is driven as-is on the unmasked lines.
- R5: In broadcast mode the target is accepted when it has at least one low bit and no low bit sits on a masked line; otherwise it is rejected as in R3.
- R6: A release request while granted makes every line high and drops `granted` on the next edge.
- R7: After a release, a selection that differs from the released one is not driven until GAP_CYCLES edges after the release edge. GAP_CYCLES is the minimum gap rounded up to whole clock periods.
- R8: Re-asserting the same selection that was just released is granted on the next edge, with no gap.
- R9: A line whose `line_mask` bit is 0 is high at all times, in every mode, and reacts to a mask change without waiting for a clock edge.
- R10: While `enable` is low, all lines are high and `granted` is low. Assert requests are ignored, and re-enabling does not restore a prior selection.
- R11: While granted, new target loads and further assert requests do not change the driven lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Block enable; low forces all lines high |
| mode | input | 2 | Selection style: 00 single, 01 decoder, 10 broadcast |
| line_mask | input | NUM_LINES | Per-line enable, 1 = line usable |
| sel_load | input | 1 | Load `sel_in` as the stored target |
| sel_in | input | NUM_LINES | Target pattern or code, active low |
| assert_req | input | 1 | Request to drive the stored target |
| release_req | input | 1 | Request to release the lines |
| ss_n | output | NUM_LINES | Slave-select lines, active low |
| granted | output | 1 | Lines are valid for a transfer |
| sel_err | output | 1 | Last request was rejected |

## Verification
The bench builds the block with four lines, an 8000 ps clock period and a 40000 ps minimum gap, which gives a five-cycle gap. That short gap keeps the exact cycle of a delayed grant within a short count. Four lines are enough to form targets with zero, one and two low bits, to place a low bit on a masked line, and to drive an all-zero decoder code.

// File: rtl/spi_ss_ctrl.sv
module spi_ss_ctrl #(
  parameter int NUM_LINES     = 4,
  parameter int CLK_PERIOD_PS = 8000,
  parameter int MIN_GAP_PS    = 62000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic [1:0]           mode,
  input  logic [NUM_LINES-1:0] line_mask,
  input  logic                 sel_load,
  input  logic [NUM_LINES-1:0] sel_in,
  input  logic                 assert_req,
  input  logic                 release_req,
  output logic [NUM_LINES-1:0] ss_n,
  output logic                 granted,
  output logic                 sel_err
);
  localparam int GAP_RAW    = (MIN_GAP_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int GAP_CYCLES = (GAP_RAW < 1) ? 1 : GAP_RAW;
  localparam int CW         = $clog2(GAP_CYCLES + 1);
  localparam logic [1:0] M_SINGLE = 2'b00, M_DECODE = 2'b01, M_BCAST = 2'b10;
  localparam logic [NUM_LINES-1:0] SLAVE0 = {{(NUM_LINES-1){1'b1}}, 1'b0};

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_ACT} st_t;

  st_t                  st;
  logic [NUM_LINES-1:0] sel_q, act_sel, last_sel;
  logic [1:0]           act_mode;
  logic [CW-1:0]        gap_cnt;
  logic                 err_q;

  logic [NUM_LINES-1:0] want_low, bad_low;
  logic                 req_ok, gap_ok;

  assign want_low = ~sel_q;
  assign bad_low  = want_low & ~line_mask;

  always_comb begin
    unique case (mode)
      M_SINGLE: req_ok = ($countones(want_low) == 1) && (bad_low == '0);
      M_DECODE: req_ok = 1'b1;
      M_BCAST:  req_ok = (want_low != '0) && (bad_low == '0);
      default:  req_ok = 1'b0;
    endcase
  end

  assign gap_ok = (gap_cnt == '0) || (sel_q == last_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      sel_q    <= SLAVE0;
      act_sel  <= '1;
      last_sel <= '1;
      act_mode <= M_SINGLE;
      gap_cnt  <= '0;
      err_q    <= 1'b0;
    end else begin
      if (sel_load) sel_q <= sel_in;
      if (gap_cnt != '0) gap_cnt <= gap_cnt - 1'b1;
      unique case (st)
        S_IDLE: if (enable && assert_req) begin
          if (req_ok) begin
            act_sel  <= sel_q;
            act_mode <= mode;
            err_q    <= 1'b0;
            st       <= gap_ok ? S_ACT : S_WAIT;
          end else begin
            err_q <= 1'b1;
          end
        end
        S_WAIT: begin
          if (!enable || release_req) st <= S_IDLE;
          else if (gap_cnt == '0 || act_sel == last_sel) st <= S_ACT;
        end
        S_ACT: if (!enable || release_req) begin
          st       <= S_IDLE;
          last_sel <= act_sel;
          gap_cnt  <= CW'(GAP_CYCLES - 1);
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign granted = enable && (st == S_ACT);
  assign ss_n    = granted ? (act_sel | ~line_mask) : '1;
  assign sel_err = err_q;

  logic [CW-1:0] hi_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      hi_run <= CW'(GAP_CYCLES);
    else if (granted)                hi_run <= '0;
    else if (hi_run != CW'(GAP_CYCLES)) hi_run <= hi_run + 1'b1;
  end

  // R2
  single_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (granted && act_mode == M_SINGLE) |-> ($countones(~ss_n) <= 1));
  // R6
  release_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (granted && release_req) |=> (!granted && ss_n == '1));
  // R7
  min_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(granted) && act_sel != last_sel) |-> (hi_run >= CW'(GAP_CYCLES)));
  // R10
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable) |=> !granted || enable);
  // R11
  hold_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (granted && enable && !release_req) |=> $stable(act_sel));
endmodule

// File: tb/spi_ss_ctrl_tb.sv
module spi_ss_ctrl_tb;
  localparam int N = 4;
  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [N-1:0] line_mask = '1, sel_in = '1;
  logic sel_load = 1'b0, assert_req = 1'b0, release_req = 1'b0;
  logic [N-1:0] ss_n;
  logic granted, sel_err;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  spi_ss_ctrl #(.NUM_LINES(N), .CLK_PERIOD_PS(8000), .MIN_GAP_PS(40000)) u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode), .line_mask(line_mask),
    .sel_load(sel_load), .sel_in(sel_in), .assert_req(assert_req),
    .release_req(release_req), .ss_n(ss_n), .granted(granted), .sel_err(sel_err));

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic load(input logic [N-1:0] v);
    sel_in = v; sel_load = 1'b1; tick(); sel_load = 1'b0;
  endtask

  task automatic req_assert();
    assert_req = 1'b1; tick(); assert_req = 1'b0;
  endtask

  task automatic req_release();
    release_req = 1'b1; tick(); release_req = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 ss_n reset", ss_n, 4'hF);
    chk("R1 granted reset", granted, 0);
    chk("R1 err reset", sel_err, 0);
    req_assert();
    chk("R1 default slave0", ss_n, 4'hE);
    chk("R2 granted", granted, 1);
    req_release();
    chk("R6 lines high", ss_n, 4'hF);
    chk("R6 granted low", granted, 0);
  endtask

  task automatic t_same_and_gap();
    int n;
    req_assert();
    chk("R8 same reselect immediate", granted, 1);
    chk("R8 lines", ss_n, 4'hE);
    load(4'hD);
    chk("R11 load while active", ss_n, 4'hE);
    req_assert();
    chk("R11 assert while active", ss_n, 4'hE);
    req_release();
    n = 0;
    assert_req = 1'b1; tick(); assert_req = 1'b0; n = 1;
    while (!granted && n < 20) begin
      chk("R7 high during gap", ss_n, 4'hF);
      tick(); n++;
    end
    chk("R7 gap cycles", n, 5);
    chk("R7 new select", ss_n, 4'hD);
    req_release(); tick(6);
  endtask

  task automatic t_single_err();
    load(4'hC); req_assert();
    chk("R3 two low rejected", sel_err, 1);
    chk("R3 no grant", granted, 0);
    chk("R3 lines high", ss_n, 4'hF);
    load(4'hF); req_assert();
    chk("R3 none low rejected", sel_err, 1);
    line_mask = 4'hB; load(4'hB); req_assert();
    chk("R3 masked target rejected", sel_err, 1);
    chk("R3 masked no grant", granted, 0);
    line_mask = 4'hF;
    mode = 2'b11; load(4'h7); req_assert();
    chk("R3 mode 11 rejected", sel_err, 1);
    mode = 2'b00; req_assert();
    chk("R3 err cleared", sel_err, 0);
    chk("R2 single line", ss_n, 4'h7);
    req_release(); tick(6);
  endtask

  task automatic t_decoder();
    mode = 2'b01; load(4'h4); req_assert();
    chk("R4 code driven", ss_n, 4'h4);
    chk("R4 granted", granted, 1);
    line_mask = 4'hE; #1;
    chk("R9 mask immediate", ss_n, 4'h5);
    line_mask = 4'hF;
    req_release(); tick(6);
    load(4'h0); req_assert();
    chk("R4 all-zero code", ss_n, 4'h0);
    req_release(); tick(6);
  endtask

  task automatic t_bcast();
    mode = 2'b10; load(4'hA); req_assert();
    chk("R5 two lines low", ss_n, 4'hA);
    chk("R5 err clear", sel_err, 0);
    req_release(); tick(6);
    load(4'hF); req_assert();
    chk("R5 empty rejected", sel_err, 1);
    line_mask = 4'hE; load(4'hC); req_assert();
    chk("R5 masked rejected", sel_err, 1);
    chk("R9 masked line high", ss_n[0], 1);
    line_mask = 4'hF; mode = 2'b00;
  endtask

  task automatic t_disable();
    load(4'hE); tick(6); req_assert();
    chk("R10 pre active", granted, 1);
    enable = 1'b0; #1;
    chk("R10 lines high", ss_n, 4'hF);
    chk("R10 granted low", granted, 0);
    tick(); req_assert(); tick();
    chk("R10 assert ignored", ss_n, 4'hF);
    enable = 1'b1; tick();
    chk("R10 no restore", granted, 0);
  endtask

  initial begin
    fork
      begin
        tick(3); rst_n = 1'b1; enable = 1'b1; tick();
        t_reset();
        t_same_and_gap();
        t_single_err();
        t_decoder();
        t_bcast();
        t_disable();
      end
      begin
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule